// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit

This block is the purely combinational datapath element that sits between the accumulator and the rest of an 8-bit processor. The accumulator supplies operand A, and a register or memory word supplies operand B. A 4-bit operation code picks one of eight functions. The block returns an 8-bit result together with carry, zero and negative status bits. There is no storage inside it: the result and flags settle within the same cycle as the inputs, and the surrounding control logic decides whether to latch them.

Addition, subtraction, increment and decrement all go through one adder. Before it enters the adder, operand B passes through a row of XOR gates controlled by a subtract bit. The same subtract bit also drives the adder's carry input, so A minus B is formed as A plus the two's complement of B. For increment and decrement, the adder's B input is forced to all zeros or all ones instead. The adder forms every carry in parallel from per-bit generate (A AND B) and propagate (A XOR B) terms. It does not pass a carry from bit to bit.

Top module: `alu8_core`

## Requirements
- R1: With op_sel = 4'h0 (add), result equals (A + B) mod 256 and flag_c is 1 exactly when A + B exceeds 255.
- R2: With op_sel = 4'h1 (subtract), result equals (A - B) mod 256 and flag_c is 1 exactly when A >= B (carry set means no borrow).
- R3: With op_sel = 4'h6 (increment), result equals (A + 1) mod 256, flag_c is 1 only when A = 8'hFF, and operand B has no effect.
- R4: With op_sel = 4'h7 (decrement), result equals (A - 1) mod 256, flag_c is 1 unless A = 8'h00, and operand B has no effect.
- R5: op_sel = 4'h2 gives A AND B, 4'h3 gives A OR B, 4'h4 gives A XOR B, each bit by bit, with flag_c = 0.
- R6: With op_sel = 4'h5 (complement), result equals the bitwise inverse of A, flag_c = 0, and operand B has no effect.
- R7: flag_z is 1 exactly when all 8 result bits are 0, for every op_sel value.
- R8: flag_n always equals result bit 7.
- R9: The unused codes op_sel = 4'h8 to 4'hF give result 8'h00, flag_c = 0, flag_z = 1 and flag_n = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (encodings in R1 to R9) |
| opnd_a | input | 8 | Operand A, from the accumulator |
| opnd_b | input | 8 | Operand B, from a register or memory |
| result | output | 8 | Operation result |
| flag_c | output | 1 | Carry-out of the adder, or 0 for logic operations |
| flag_z | output | 1 | Result is all zeros |
| flag_n | output | 1 | Copy of result bit 7 |

## Verification
Two flags can be set by the same operation: a carry and a zero result. Examples are adding 8'h01 to 8'hFF, incrementing 8'hFF, subtracting equal operands, and decrementing 8'h01. The bench drives each of these from the boundary operand set (00, 01, 7F, 80, FF crossed with every code). It then checks result, carry, zero and negative together against a behavioural integer model on the following clock. Random operand pairs cover the cases where only one of the two flags, or neither, is set.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'h0,
    OP_SUB = 4'h1,
    OP_AND = 4'h2,
    OP_OR  = 4'h3,
    OP_XOR = 4'h4,
    OP_NOT = 4'h5,
    OP_INC = 4'h6,
    OP_DEC = 4'h7
  } alu_op_e;

  // Source selected for the adder's B input
  typedef enum logic [1:0] {
    BSRC_OPND = 2'd0,
    BSRC_ZERO = 2'd1,
    BSRC_ONES = 2'd2
  } bsrc_e;
endpackage

// File: rtl/alu8_bcond.sv
module alu8_bcond #(
  parameter int W = 8
) (
  input  logic [W-1:0] b_in,
  input  logic         invert,
  output logic [W-1:0] b_out
);
  // One XOR per bit: pass-through when invert=0, complement when invert=1
  for (genvar gi = 0; gi < W; gi++) begin : g_xor
    assign b_out[gi] = b_in[gi] ^ invert;
  end
endmodule

// File: rtl/alu8_cla.sv
module alu8_cla #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W:0]   carry;

  assign gen   = a & b;
  assign prop  = a ^ b;
  assign carry[0] = cin;

  // Each carry is a flat sum of products over generate/propagate terms
  for (genvar gi = 0; gi < W; gi++) begin : g_carry
    logic c_acc;
    logic term;
    always_comb begin
      c_acc = 1'b0;
      for (int j = 0; j <= gi; j++) begin
        term = gen[j];
        for (int k = j + 1; k <= gi; k++) term = term & prop[k];
        c_acc = c_acc | term;
      end
      term = cin;
      for (int k = 0; k <= gi; k++) term = term & prop[k];
      carry[gi+1] = c_acc | term;
    end
  end

  assign sum  = prop ^ carry[W-1:0];
  assign cout = carry[W];

  // R1
  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      add_sum_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
        else $error("adder mismatch");
    end
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int W = 8
) (
  input  alu8_pkg::alu_op_e op,
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  output logic [W-1:0]      y,
  output logic              hit
);
  import alu8_pkg::*;

  always_comb begin
    hit = 1'b1;
    unique case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOT:  y = ~a;
      default: begin
        y   = '0;
        hit = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int W = 8
) (
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] result,
  output logic         flag_c,
  output logic         flag_z,
  output logic         flag_n
);
  import alu8_pkg::*;

  localparam logic [W-1:0] ONES = {W{1'b1}};

  alu_op_e      op;
  logic         arith_en;
  logic         sub_ctl;
  logic         cin_force;
  bsrc_e        bsrc;
  logic [W-1:0] b_sel;
  logic [W-1:0] b_cond;
  logic [W-1:0] add_sum;
  logic         add_cout;
  logic [W-1:0] log_y;
  logic         log_hit;

  assign op = alu_op_e'(op_sel);

  // Decode: arithmetic steering and subtract control
  always_comb begin
    arith_en  = 1'b0;
    sub_ctl   = 1'b0;
    cin_force = 1'b0;
    bsrc      = BSRC_OPND;
    case (op_sel)
      OP_ADD: arith_en = 1'b1;
      OP_SUB: begin
        arith_en = 1'b1;
        sub_ctl  = 1'b1;
      end
      OP_INC: begin
        arith_en  = 1'b1;
        cin_force = 1'b1;
        bsrc      = BSRC_ZERO;
      end
      OP_DEC: begin
        arith_en = 1'b1;
        bsrc     = BSRC_ONES;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (bsrc)
      BSRC_ZERO: b_sel = '0;
      BSRC_ONES: b_sel = ONES;
      default:   b_sel = opnd_b;
    endcase
  end

  alu8_bcond #(.W(W)) u_bcond (
    .b_in  (b_sel),
    .invert(sub_ctl),
    .b_out (b_cond)
  );

  alu8_cla #(.W(W)) u_cla (
    .a   (opnd_a),
    .b   (b_cond),
    .cin (sub_ctl | cin_force),
    .sum (add_sum),
    .cout(add_cout)
  );

  alu8_logic #(.W(W)) u_logic (
    .op (op),
    .a  (opnd_a),
    .b  (opnd_b),
    .y  (log_y),
    .hit(log_hit)
  );

  // Result and flag merge
  always_comb begin
    if (arith_en) begin
      result = add_sum;
      flag_c = add_cout;
    end else begin
      result = log_hit ? log_y : '0;
      flag_c = 1'b0;
    end
  end

  assign flag_z = ~|result;
  assign flag_n = result[W-1];

  always_comb begin
    if (!$isunknown({op_sel, opnd_a, opnd_b})) begin
      // R2
      sub_borrow_chk: assert (op_sel != 4'h1 || flag_c == (opnd_a >= opnd_b))
        else $error("subtract carry wrong");
      // R3
      inc_wrap_chk: assert (op_sel != 4'h6 || opnd_a != ONES || (flag_c && flag_z))
        else $error("increment wrap wrong");
      // R4
      dec_carry_chk: assert (op_sel != 4'h7 || flag_c == (opnd_a != '0))
        else $error("decrement carry wrong");
      // R5
      logic_carry_chk: assert (!(op_sel inside {4'h2, 4'h3, 4'h4, 4'h5}) || !flag_c)
        else $error("logic op set carry");
      // R9
      unused_op_chk: assert (!op_sel[3] || (result == '0 && !flag_c && flag_z && !flag_n))
        else $error("unused code not quiet");
    end
  end
endmodule

// File: tb/alu8_core_tb.sv
module alu8_core_tb_top;
  logic       clk;
  logic [3:0] op_sel;
  logic [7:0] opnd_a;
  logic [7:0] opnd_b;
  logic [7:0] result;
  logic       flag_c, flag_z, flag_n;

  int n_chk;
  int n_fail;
  bit done;

  alu8_core dut_i (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .result(result), .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic string req_of(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2, 3, 4: return "R5";
      5: return "R6";
      6: return "R3";
      7: return "R4";
      default: return "R9";
    endcase
  endfunction

  // Behavioural model: returns {c, result}
  function automatic logic [8:0] model(input int op, input int a, input int b);
    int r;
    int c;
    c = 0;
    case (op)
      0: begin r = a + b; c = (r > 255); end
      1: begin r = a - b + 256; c = (a >= b); end
      2: r = a & b;
      3: r = a | b;
      4: r = a ^ b;
      5: r = 255 - a;
      6: begin r = a + 1; c = (a == 255); end
      7: begin r = a + 255; c = (a != 0); end
      default: r = 0;
    endcase
    return {c[0], 8'(r % 256)};
  endfunction

  task automatic apply_and_check(input int op, input int a, input int b);
    logic [8:0] exp;
    logic       ez, en;
    @(negedge clk);
    op_sel = 4'(op);
    opnd_a = 8'(a);
    opnd_b = 8'(b);
    exp = model(op, a, b);
    ez  = (exp[7:0] == 8'h00);
    en  = exp[7];
    @(posedge clk);
    #1;
    n_chk++;
    if (result !== exp[7:0] || flag_c !== exp[8]) begin
      n_fail++;
      $display("FAIL %s op=%0h a=%02h b=%02h actual res=%02h c=%0b expected res=%02h c=%0b",
               req_of(op), op, a, b, result, flag_c, exp[7:0], exp[8]);
    end
    n_chk++;
    if (flag_z !== ez) begin  // R7
      n_fail++;
      $display("FAIL R7 op=%0h a=%02h b=%02h actual z=%0b expected z=%0b", op, a, b, flag_z, ez);
    end
    n_chk++;
    if (flag_n !== en) begin  // R8
      n_fail++;
      $display("FAIL R8 op=%0h a=%02h b=%02h actual n=%0b expected n=%0b", op, a, b, flag_n, en);
    end
  endtask

  initial begin
    int bnd[5];
    bnd = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
    n_chk = 0;
    n_fail = 0;
    op_sel = 4'h0;
    opnd_a = 8'h00;
    opnd_b = 8'h00;
    // Named corners: carry and zero together (R1, R2, R3, R4)
    apply_and_check(0, 8'hFF, 8'h01);
    apply_and_check(1, 8'h09, 8'h05);
    apply_and_check(1, 8'h42, 8'h42);
    apply_and_check(6, 8'hFF, 8'h3C);
    apply_and_check(7, 8'h01, 8'hA5);
    apply_and_check(7, 8'h00, 8'h00);
    // B must not matter for INC/DEC/NOT (R3, R4, R6)
    apply_and_check(6, 8'h10, 8'hFF);
    apply_and_check(5, 8'h0F, 8'hF0);
    // Boundary sweep over every code including unused ones (R5, R9)
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          apply_and_check(op, bnd[i], bnd[j]);
    // Random operands
    for (int k = 0; k < 3000; k++)
      apply_and_check(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)),
                      int'($urandom_range(0, 255)));
    done = 1'b1;
  end

  initial begin
    done = 1'b0;
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule